// File: doc/BRIEF.md
# Per-Bit Selectable-Clock Input Sampler

This block is the input-capture stage of a general-purpose pin bank. For every input pin it keeps a captured value that the register file reads. Each pin picks its own capture source. With its external-clock enable bit clear, the captured value simply tracks the pin through a short synchroniser. With the enable bit set, the value is refreshed only when a qualifying edge arrives on a separate external sampling-clock pin. A second per-pin select bit chooses whether that edge is the rising or the falling one.

All logic runs on the system clock. The external sampling clock is never used as a clock. It is passed through a two-flop synchroniser and its edges are found by comparing the synchronised level with the level one system clock earlier. The data pins pass through a matching two-flop synchroniser, so the pin value stored on a detected edge is the one present when that edge occurred. The enable and select vectors are full 32-bit register images. Only the bits that map to implemented pins have any effect.

The interface carries level-type register data with no transfer semantics, so there is no valid/ready handshake and no back-pressure. The captured value is continuously available and is read at will.

Top module: `pin_capture`

## Requirements
- R1: While reset is asserted, and on the first two system clock edges after reset is released, `cap_o` is all zeros.
- R2: For a pin whose enable bit is 0, `cap_o` shows the pin value sampled at system clock edge k from just after edge k+1, that is, within two system clocks.
- R3: For a pin whose enable bit is 1 and whose select bit is 0 (rising edge), a rising transition of `xclk_i` first seen at system edge k stores the pin value sampled at edge k. That value appears on `cap_o` just after edge k+2.
- R4: For a pin whose enable bit is 1 and whose select bit is 1 (falling edge), a falling transition of `xclk_i` first seen at edge k stores the pin value sampled at edge k. That value appears on `cap_o` just after edge k+2.
- R5: For a pin with its enable bit set, `cap_o` stays unchanged for as long as no qualifying `xclk_i` edge occurs, however the pins change and however many clocks pass.
- R6: Bits of `xclk_en_i` and `xclk_fall_i` at positions NPINS and above have no effect on `cap_o`.
- R7: When each high phase and each low phase of `xclk_i` lasts at least two system clocks, every edge is detected exactly once. No edge is lost and no edge is duplicated.
- R8: The source (system or external) and the active edge are chosen independently for each pin. In one run, pins in system, rising and falling mode each behave as stated in R2, R3 and R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins_i | input | NPINS | Raw asynchronous input pins |
| xclk_i | input | 1 | Asynchronous external sampling clock pin |
| xclk_en_i | input | REG_W | Per-pin external-clock enable, 1 = capture on external edge |
| xclk_fall_i | input | REG_W | Per-pin edge select, 0 = rising edge, 1 = falling edge |
| cap_o | output | NPINS | Captured input value, synchronous to `clk` |

## Verification
The bench aims at the alignment between a detected external edge and the data it stores. A design whose data synchroniser is one stage shorter or longer than the clock synchroniser would store the pin value from a neighbouring cycle. External clock phases of exactly two system clocks are used to expose edge detectors that miss or double-count an edge. A detector like that would skip a capture or refresh the value a cycle late. Long stretches with the external clock idle while the pins change would reveal a design that leaks system-rate updates into externally clocked pins. Mixed per-pin modes and garbage in the unimplemented register bits would catch a swapped edge select or decoding that reaches past the pin count.

// File: rtl/pcap_pkg.sv
package pcap_pkg;

  // Meaning of one bit of the edge-select vector.
  typedef enum logic {
    SEL_RISE = 1'b0,
    SEL_FALL = 1'b1
  } edge_sel_e;

  // One-cycle event pulses derived from the external sampling clock.
  typedef struct packed {
    logic rise;
    logic fall;
  } edge_evt_t;

endpackage

// File: rtl/pcap_sync.sv
module pcap_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '0;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) begin
        chain[i] <= chain[i-1];
      end
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/pcap_edge.sv
module pcap_edge
  import pcap_pkg::*;
#(
  parameter int unsigned STAGES = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      xclk_i,
  output edge_evt_t evt
);

  logic lvl_now;
  logic lvl_prev;

  pcap_sync #(.W(1), .STAGES(STAGES)) u_xsync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (xclk_i),
    .q     (lvl_now)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_prev <= 1'b0;
    end else begin
      lvl_prev <= lvl_now;
    end
  end

  always_comb begin
    evt.rise = lvl_now & ~lvl_prev;
    evt.fall = ~lvl_now & lvl_prev;
  end

endmodule

// File: rtl/pcap_bits.sv
module pcap_bits
  import pcap_pkg::*;
#(
  parameter int unsigned NPINS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_s,
  input  edge_evt_t        evt,
  input  logic [NPINS-1:0] ext_en,
  input  logic [NPINS-1:0] fall_sel,
  output logic [NPINS-1:0] cap_o
);

  for (genvar b = 0; b < NPINS; b++) begin : g_bit
    edge_sel_e sel;
    logic      hit;
    logic      held;

    assign sel = edge_sel_e'(fall_sel[b]);

    always_comb begin
      unique case (sel)
        SEL_RISE: hit = evt.rise;
        SEL_FALL: hit = evt.fall;
        default:  hit = 1'b0;
      endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        held <= 1'b0;
      end else if (ext_en[b] && hit) begin
        held <= pin_s[b];
      end
    end

    assign cap_o[b] = ext_en[b] ? held : pin_s[b];
  end

endmodule

// File: rtl/pin_capture.sv
module pin_capture
  import pcap_pkg::*;
#(
  parameter int unsigned NPINS  = 8,
  parameter int unsigned REG_W  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pins_i,
  input  logic             xclk_i,
  input  logic [REG_W-1:0] xclk_en_i,
  input  logic [REG_W-1:0] xclk_fall_i,
  output logic [NPINS-1:0] cap_o
);

  localparam int unsigned SPARE = REG_W - NPINS;

  logic [NPINS-1:0] pin_s;
  edge_evt_t        evt_w;
  logic             rise_w;
  logic             fall_w;

  pcap_sync #(.W(NPINS), .STAGES(STAGES)) u_psync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pins_i),
    .q     (pin_s)
  );

  pcap_edge #(.STAGES(STAGES)) u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .xclk_i (xclk_i),
    .evt    (evt_w)
  );

  assign rise_w = evt_w.rise;
  assign fall_w = evt_w.fall;

  pcap_bits #(.NPINS(NPINS)) u_bits (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_s    (pin_s),
    .evt      (evt_w),
    .ext_en   (xclk_en_i[NPINS-1:0]),
    .fall_sel (xclk_fall_i[NPINS-1:0]),
    .cap_o    (cap_o)
  );

  if (SPARE > 0) begin : g_spare
    logic unused_hi;
    assign unused_hi = ^{xclk_en_i[REG_W-1:NPINS], xclk_fall_i[REG_W-1:NPINS]};
  end

endmodule

// File: rtl/pcap_chk.sv
module pcap_chk #(
  parameter int unsigned NPINS = 8,
  parameter int unsigned REG_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NPINS-1:0] pins_i,
  input logic [REG_W-1:0] xclk_en_i,
  input logic [REG_W-1:0] xclk_fall_i,
  input logic [NPINS-1:0] cap_o,
  input logic             rise,
  input logic             fall
);

  // Edges seen since reset release, saturating at 3.
  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age <= 2'd0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  p_reset_zero_r1: assert property (@(posedge clk) !rst_n |-> cap_o == '0);

  p_single_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
  p_single_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !fall);

  for (genvar b = 0; b < NPINS; b++) begin : g_chk
    p_sys_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (age >= 2'd2 && !xclk_en_i[b]) |-> cap_o[b] == $past(pins_i[b], 2));

    p_rise_take_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (age == 2'd3 && xclk_en_i[b] && $past(xclk_en_i[b]) && !$past(xclk_fall_i[b]) && $past(rise))
      |-> cap_o[b] == $past(pins_i[b], 3));

    p_fall_take_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (age == 2'd3 && xclk_en_i[b] && $past(xclk_en_i[b]) && $past(xclk_fall_i[b]) && $past(fall))
      |-> cap_o[b] == $past(pins_i[b], 3));

    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (age >= 2'd1 && xclk_en_i[b] && $past(xclk_en_i[b]) && !$past(rise) && !$past(fall))
      |-> $stable(cap_o[b]));
  end

endmodule

bind pin_capture pcap_chk #(.NPINS(NPINS), .REG_W(REG_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .pins_i      (pins_i),
  .xclk_en_i   (xclk_en_i),
  .xclk_fall_i (xclk_fall_i),
  .cap_o       (cap_o),
  .rise        (rise_w),
  .fall        (fall_w)
);

// File: tb/pin_capture_bench.sv
module pin_capture_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NP = 8;
  localparam int RW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] pins_i = '0;
  logic          xclk_i = 1'b0;
  logic [RW-1:0] xclk_en_i = '0;
  logic [RW-1:0] xclk_fall_i = '0;
  logic [NP-1:0] cap_o;

  int    errors = 0;
  int    checks = 0;
  bit    finished = 1'b0;
  string cur_req = "R1";

  pin_capture #(.NPINS(NP), .REG_W(RW)) u_pin_capture (
    .clk         (clk),
    .rst_n       (rst_n),
    .pins_i      (pins_i),
    .xclk_i      (xclk_i),
    .xclk_en_i   (xclk_en_i),
    .xclk_fall_i (xclk_fall_i),
    .cap_o       (cap_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Reference model: history of sampled inputs, newest first.
  bit            xq[$];
  logic [NP-1:0] pq[$];
  logic [NP-1:0] held_m = '0;

  initial begin
    xq = '{0, 0, 0, 0};
    pq = '{'0, '0, '0, '0};
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      xq = '{0, 0, 0, 0};
      pq = '{'0, '0, '0, '0};
      held_m = '0;
    end else begin
      xq.push_front(xclk_i);
      void'(xq.pop_back());
      pq.push_front(pins_i);
      void'(pq.pop_back());
      for (int b = 0; b < NP; b++) begin
        bit up, dn;
        up = xq[2] && !xq[3];
        dn = !xq[2] && xq[3];
        if (xclk_en_i[b] && ((!xclk_fall_i[b] && up) || (xclk_fall_i[b] && dn)))
          held_m[b] = pq[2][b];
      end
    end
  end

  always @(negedge clk) begin
    if (!finished) begin
      logic [NP-1:0] exp;
      for (int b = 0; b < NP; b++)
        exp[b] = xclk_en_i[b] ? held_m[b] : pq[1][b];
      checks++;
      if (cap_o !== exp) begin
        errors++;
        $display("FAIL %s: cap_o=%h expected %h at %0t", cur_req, cap_o, exp, $time);
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // Random pins every cycle; xclk toggled with phases of lo..hi clocks.
  task automatic run_ext(int cycles, int lo, int hi, bit garbage_hi);
    int left = lo + ($urandom % (hi - lo + 1));
    for (int i = 0; i < cycles; i++) begin
      tick();
      pins_i = NP'($urandom);
      if (garbage_hi) begin
        xclk_en_i[RW-1:NP]   = (RW-NP)'($urandom);
        xclk_fall_i[RW-1:NP] = (RW-NP)'($urandom);
      end
      left--;
      if (left == 0) begin
        xclk_i = ~xclk_i;
        left = lo + ($urandom % (hi - lo + 1));
      end
    end
  endtask

  initial begin
    // R1: reset held with external mode armed and xclk high
    xclk_en_i = '1;
    xclk_i = 1'b1;
    pins_i = '1;
    repeat (4) tick();
    rst_n = 1'b1;
    repeat (3) tick();

    // R2: system clock mode, random pins
    cur_req = "R2";
    xclk_en_i = '0;
    xclk_i = 1'b0;
    for (int i = 0; i < 60; i++) begin
      tick();
      pins_i = NP'($urandom);
    end

    // R3: external rising edge on every pin
    cur_req = "R3";
    xclk_en_i = '1;
    xclk_fall_i = '0;
    run_ext(300, 2, 6, 1'b0);

    // R4: external falling edge on every pin
    cur_req = "R4";
    xclk_fall_i = '1;
    run_ext(300, 2, 6, 1'b0);

    // R5: external mode, xclk idle, pins keep changing
    cur_req = "R5";
    xclk_fall_i = '0;
    for (int i = 0; i < 80; i++) begin
      tick();
      pins_i = NP'($urandom);
    end

    // R7: phases of exactly two system clocks
    cur_req = "R7";
    run_ext(400, 2, 2, 1'b0);
    xclk_fall_i = '1;
    run_ext(400, 2, 2, 1'b0);

    // R8: mixed per-pin modes (bits 0-2 system, 3-5 rise, 6-7 fall)
    cur_req = "R8";
    xclk_en_i   = 32'h0000_00F8;
    xclk_fall_i = 32'h0000_00C0;
    run_ext(500, 2, 5, 1'b0);
    for (int k = 0; k < 6; k++) begin
      tick();
      xclk_en_i   = {24'h0, 8'($urandom)};
      xclk_fall_i = {24'h0, 8'($urandom)};
      run_ext(120, 2, 4, 1'b0);
    end

    // R6: garbage in unimplemented register bits
    cur_req = "R6";
    xclk_en_i[NP-1:0]   = 8'h5A;
    xclk_fall_i[NP-1:0] = 8'h0F;
    run_ext(400, 2, 5, 1'b1);
    xclk_en_i[NP-1:0] = 8'h00;
    run_ext(100, 2, 5, 1'b1);

    tick();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      finished = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog (%s): run did not complete, expected completion", cur_req);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule